// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block collects interrupt requests from up to four CAN controller channels and drives one shared, level-sensitive interrupt line to a host. Each channel owns one bit of a 16-bit sticky status register and the bit at the same position of a 16-bit enable register. The bits are spread across the word (not packed), so the host-side handler tests a fixed mask for each channel. A status bit latches when its channel's request rises. It stays set until the host writes a one to that bit position. The interrupt line is high while any status bit that is also enabled is set.

The number of channels fitted is worked out from a 16-bit board identifier input by comparing it against thresholds. Requests from channels that are not fitted are dropped, and their bits read as zero. A small control byte sits next to the two registers. Writing one code to it holds the channels in reset, and writing a second code releases them. Software keeps the reset asserted for a few milliseconds between the two writes. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is sampled high.

Top module: `irqagg_top`

## Requirements
- R1: After a synchronous reset the status, enable and control registers all read 0x0000, `irq_out` is low and `chan_rst_out` is low.
- R2: Address 0x0 selects the status register, address 0x2 selects the enable register and address 0x4 selects the control byte, which reads in bits 7:0 with bits 15:8 at zero. Channel 0 owns bit 1 (0x0002), channel 1 owns bit 0 (0x0001), channel 2 owns bit 6 (0x0040) and channel 3 owns bit 7 (0x0080), in both the status and the enable register.
- R3: A status bit is set at the clock edge where its present channel's request is high and was low at the previous edge. A request held high does not set the bit again after it has been cleared.
- R4: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a rising request and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R6: `irq_out` is high exactly when some bit is set in both the status and the enable register. Writing 0x0000 to the enable register forces `irq_out` low.
- R7: `chan_count` is derived from `board_id`. An identifier of 12 or more gives 4 channels, 10 or 11 gives 3, 4 to 9 gives 2, and below 4 gives 1. The channels present are 0 up to count-1.
- R8: Requests from channels that are not present set nothing. The status bits of absent channels read 0, and a bit that was set is dropped when its channel stops being present.
- R9: Bits of the status and enable registers that no channel owns always read 0 and ignore writes.
- R10: Writing 0x05 to the control byte drives `chan_rst_out` high, and writing 0x04 drives it low. Any other value is stored and read back but leaves `chan_rst_out` unchanged. Bits 15:8 of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 4 | Interrupt request level from each channel |
| board_id | input | 16 | Board identifier used to decode the number of channels |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Shared interrupt line to the host |
| chan_rst_out | output | 1 | Reset to the channels |
| chan_count | output | 3 | Decoded number of channels present |

## Verification
The assertions check these properties on every cycle:
- Unowned bits stay at zero.
- A rising request from a present channel lands in the status register.
- A clearing write with no competing set empties the written bits.
- Absent channels never hold a bit.
- A zero enable keeps the line low.
- The reset output follows the two control codes.
- The channel count stays between one and four.

Other behaviour only the bench scenarios can show:
- The exact scattered bit each channel lands on.
- A held request not setting its bit again after a clear.
- The set-over-clear priority at a shared edge.
- Every threshold of the identifier decode.
- Stored control values that leave the reset output alone.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NCH_MAX  = 4;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 4;
    localparam int ID_W     = 16;
    localparam int CTRL_W   = 8;
    localparam int CNT_W    = $clog2(NCH_MAX + 1);

    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h4;

    localparam logic [CTRL_W-1:0] CTRL_HOLD_RST = 8'h05;
    localparam logic [CTRL_W-1:0] CTRL_FREE_RST = 8'h04;

    localparam logic [ID_W-1:0] ID_MIN_4CH = 16'd12;
    localparam logic [ID_W-1:0] ID_MIN_3CH = 16'd10;
    localparam logic [ID_W-1:0] ID_MIN_2CH = 16'd4;

    typedef enum logic [1:0] {
        SEL_STAT,
        SEL_EN,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    // Register bit owned by a channel; the layout is decoded by host software.
    function automatic logic [REG_W-1:0] chan_bit(input int ch);
        logic [REG_W-1:0] b;
        case (ch)
            0:       b = 16'h0002;
            1:       b = 16'h0001;
            2:       b = 16'h0040;
            3:       b = 16'h0080;
            default: b = '0;
        endcase
        return b;
    endfunction

    function automatic logic [REG_W-1:0] all_chan_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int c = 0; c < NCH_MAX; c++) m |= chan_bit(c);
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] id_to_count(input logic [ID_W-1:0] id);
        logic [CNT_W-1:0] n;
        if (id >= ID_MIN_4CH)      n = CNT_W'(4);
        else if (id >= ID_MIN_3CH) n = CNT_W'(3);
        else if (id >= ID_MIN_2CH) n = CNT_W'(2);
        else                       n = CNT_W'(1);
        return n;
    endfunction

    function automatic reg_sel_t addr_to_sel(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        case (a)
            ADDR_STAT: s = SEL_STAT;
            ADDR_EN:   s = SEL_EN;
            ADDR_CTRL: s = SEL_CTRL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqagg_chan_decode.sv
module irqagg_chan_decode
    import irqagg_pkg::*;
(
    input  logic [ID_W-1:0]    board_id,
    output logic [CNT_W-1:0]   chan_count,
    output logic [NCH_MAX-1:0] chan_present,
    output logic [REG_W-1:0]   valid_map
);

    assign chan_count = id_to_count(board_id);

    for (genvar g = 0; g < NCH_MAX; g++) begin : g_present
        assign chan_present[g] = (CNT_W'(g) < chan_count);
    end

    always_comb begin
        valid_map = '0;
        for (int c = 0; c < NCH_MAX; c++) begin
            if (chan_present[c]) valid_map |= chan_bit(c);
        end
    end

endmodule

// File: rtl/irqagg_status.sv
module irqagg_status
    import irqagg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH_MAX-1:0] chan_req,
    input  logic [NCH_MAX-1:0] chan_present,
    input  logic [REG_W-1:0]   valid_map,
    input  logic               stat_wr,
    input  logic               en_wr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   stat_q,
    output logic [REG_W-1:0]   en_q
);

    localparam logic [REG_W-1:0] OWNED = all_chan_bits();

    logic [NCH_MAX-1:0] req_q;
    logic [NCH_MAX-1:0] req_rise;
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   clr_vec;
    logic [REG_W-1:0]   stat_d;

    for (genvar g = 0; g < NCH_MAX; g++) begin : g_edge
        assign req_rise[g] = chan_req[g] & ~req_q[g] & chan_present[g];
    end

    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH_MAX; c++) begin
            if (req_rise[c]) set_vec |= chan_bit(c);
        end
    end

    assign clr_vec = stat_wr ? wdata : '0;
    // Set takes priority over a clear in the same cycle.
    assign stat_d  = ((stat_q & ~clr_vec) | set_vec) & valid_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            req_q  <= chan_req;
            stat_q <= stat_d;
            if (en_wr) en_q <= wdata & OWNED;
        end
    end

    // R9: unowned bits never hold a one
    p_unowned_zero_r9: assert property (@(posedge clk) disable iff (rst)
        ((stat_q | en_q) & ~OWNED) == '0);

    // R3: a rising request of a present channel lands in the status register
    p_set_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    // R4: bits written as one with no competing set are emptied
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && ((wdata & ~set_vec) != '0)) |=>
            ((stat_q & $past(wdata & ~set_vec)) == '0));

    // R8: an absent channel holds no bit
    p_absent_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((stat_q & ~$past(valid_map)) == '0));

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              chan_rst_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            chan_rst_out <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata;
            if (wdata == CTRL_HOLD_RST)      chan_rst_out <= 1'b1;
            else if (wdata == CTRL_FREE_RST) chan_rst_out <= 1'b0;
        end
    end

    // R10: hold code drives reset high
    p_rst_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata == CTRL_HOLD_RST) |=> chan_rst_out);

    // R10: release code drives reset low
    p_rst_free_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata == CTRL_FREE_RST) |=> !chan_rst_out);

    // R10: other codes leave the reset output alone
    p_rst_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr || (wdata != CTRL_HOLD_RST && wdata != CTRL_FREE_RST))
            |=> $stable(chan_rst_out));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH_MAX-1:0] chan_req,
    input  logic [ID_W-1:0]    board_id,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               irq_out,
    output logic               chan_rst_out,
    output logic [CNT_W-1:0]   chan_count
);

    bus_req_t           breq;
    reg_sel_t           sel;
    logic [NCH_MAX-1:0] present;
    logic [REG_W-1:0]   valid_map;
    logic [REG_W-1:0]   stat_w;
    logic [REG_W-1:0]   en_w;
    logic [CTRL_W-1:0]  ctrl_w;

    assign breq = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};
    assign sel  = addr_to_sel(breq.addr);

    irqagg_chan_decode u_decode (
        .board_id     (board_id),
        .chan_count   (chan_count),
        .chan_present (present),
        .valid_map    (valid_map)
    );

    irqagg_status u_status (
        .clk          (clk),
        .rst          (rst),
        .chan_req     (chan_req),
        .chan_present (present),
        .valid_map    (valid_map),
        .stat_wr      (breq.wr && sel == SEL_STAT),
        .en_wr        (breq.wr && sel == SEL_EN),
        .wdata        (breq.wdata),
        .stat_q       (stat_w),
        .en_q         (en_w)
    );

    irqagg_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (breq.wr && sel == SEL_CTRL),
        .wdata        (breq.wdata[CTRL_W-1:0]),
        .ctrl_q       (ctrl_w),
        .chan_rst_out (chan_rst_out)
    );

    assign irq_out = |(stat_w & en_w);

    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = stat_w;
            SEL_EN:   bus_rdata = en_w;
            SEL_CTRL: bus_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_w};
            default:  bus_rdata = '0;
        endcase
    end

    // R6: an all-zero enable register keeps the line low
    p_mask_all_r6: assert property (@(posedge clk) disable iff (rst)
        (en_w == '0) |-> !irq_out);

    // R7: decoded count stays within one to four
    p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
        (chan_count >= CNT_W'(1)) && (chan_count <= CNT_W'(NCH_MAX)));

    // R1: registers come out of reset cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && !chan_rst_out));

endmodule

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
    import irqagg_pkg::*;

    typedef enum int {K_RDATA, K_IRQ, K_RST, K_COUNT} kind_t;
    typedef struct {
        kind_t       kind;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCH_MAX-1:0] chan_req = '0;
    logic [ID_W-1:0]    board_id = 16'd12;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [REG_W-1:0]   bus_wdata = '0;
    logic [REG_W-1:0]   bus_rdata;
    logic               irq_out;
    logic               chan_rst_out;
    logic [CNT_W-1:0]   chan_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    irqagg_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .chan_req     (chan_req),
        .board_id     (board_id),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_out      (irq_out),
        .chan_rst_out (chan_rst_out),
        .chan_count   (chan_count)
    );

    // Monitor: compares queued expectations shortly after each edge.
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RDATA: act = bus_rdata;
                K_IRQ:   act = {15'd0, irq_out};
                K_RST:   act = {15'd0, chan_rst_out};
                default: act = {13'd0, chan_count};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push_exp(input kind_t k, input logic [15:0] e, input string t);
        sb_item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        @(negedge clk);
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_read(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        push_exp(K_RDATA, e, t);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_req(input logic [NCH_MAX-1:0] m);
        @(negedge clk);
        chan_req = chan_req | m;
        @(negedge clk);
        chan_req = chan_req & ~m;
    endtask

    task automatic set_id(input logic [15:0] id, input logic [15:0] cnt, input string t);
        @(negedge clk);
        board_id = id;
        push_exp(K_COUNT, cnt, t);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_read(ADDR_STAT, 16'h0000, "R1 status after reset");
        exp_read(ADDR_EN,   16'h0000, "R1 enable after reset");
        exp_read(ADDR_CTRL, 16'h0000, "R1 control after reset");
        push_exp(K_IRQ, 16'd0, "R1 irq after reset");
        push_exp(K_RST, 16'd0, "R1 channel reset after reset");
        push_exp(K_COUNT, 16'd4, "R7 count id 12");

        // R2 / R3 scattered mapping
        pulse_req(4'b0001); exp_read(ADDR_STAT, 16'h0002, "R2 ch0 bit");
        pulse_req(4'b0010); exp_read(ADDR_STAT, 16'h0003, "R2 ch1 bit");
        pulse_req(4'b0100); exp_read(ADDR_STAT, 16'h0043, "R2 ch2 bit");
        pulse_req(4'b1000); exp_read(ADDR_STAT, 16'h00C3, "R3 ch3 bit");

        // R4 write-one-to-clear
        bus_write(ADDR_STAT, 16'h0000); exp_read(ADDR_STAT, 16'h00C3, "R4 zero write keeps");
        bus_write(ADDR_STAT, 16'h0041); exp_read(ADDR_STAT, 16'h0082, "R4 partial clear");
        push_exp(K_IRQ, 16'd0, "R6 masked by zero enable");

        // R6 / R9 enable
        bus_write(ADDR_EN, 16'hFFFF); exp_read(ADDR_EN, 16'h00C3, "R9 enable unowned bits");
        push_exp(K_IRQ, 16'd1, "R6 irq enabled");
        bus_write(ADDR_EN, 16'h0001); push_exp(K_IRQ, 16'd0, "R6 enable on clear bit");
        bus_write(ADDR_EN, 16'h0002); push_exp(K_IRQ, 16'd1, "R6 enable on set bit");
        bus_write(ADDR_EN, 16'h0000); push_exp(K_IRQ, 16'd0, "R6 mask all");
        bus_write(ADDR_STAT, 16'hFFFF); exp_read(ADDR_STAT, 16'h0000, "R9 clear all");

        // R3 held level does not re-set
        @(negedge clk); chan_req = 4'b0001;
        exp_read(ADDR_STAT, 16'h0002, "R3 level sets once");
        bus_write(ADDR_STAT, 16'h0002);
        exp_read(ADDR_STAT, 16'h0000, "R3 held request no re-set");
        @(negedge clk); chan_req = 4'b0000;

        // R5 set wins over clear
        pulse_req(4'b1000);
        @(negedge clk);
        chan_req = 4'b1000; bus_addr = ADDR_STAT; bus_wdata = 16'h0080; bus_wr = 1'b1;
        @(negedge clk);
        chan_req = 4'b0000; bus_wr = 1'b0;
        exp_read(ADDR_STAT, 16'h0080, "R5 set beats clear");
        bus_write(ADDR_STAT, 16'hFFFF);

        // R7 / R8 channel count and absent channels
        set_id(16'd4, 16'd2, "R7 count id 4");
        pulse_req(4'b1100); exp_read(ADDR_STAT, 16'h0000, "R8 absent ch2 ch3 ignored");
        pulse_req(4'b0001); exp_read(ADDR_STAT, 16'h0002, "R8 present ch0");
        set_id(16'd10, 16'd3, "R7 count id 10");
        pulse_req(4'b0100); exp_read(ADDR_STAT, 16'h0042, "R8 ch2 present");
        set_id(16'd0, 16'd1, "R7 count id 0");
        exp_read(ADDR_STAT, 16'h0002, "R8 dropped bit of absent ch2");
        set_id(16'd3,  16'd1, "R7 count id 3");
        set_id(16'd9,  16'd2, "R7 count id 9");
        set_id(16'd11, 16'd3, "R7 count id 11");
        set_id(16'hFFFF, 16'd4, "R7 count id max");

        // R10 control byte
        bus_write(ADDR_CTRL, 16'h0005);
        push_exp(K_RST, 16'd1, "R10 hold reset");
        exp_read(ADDR_CTRL, 16'h0005, "R10 control readback");
        bus_write(ADDR_CTRL, 16'h0007);
        push_exp(K_RST, 16'd1, "R10 other code keeps reset");
        exp_read(ADDR_CTRL, 16'h0007, "R10 other code stored");
        bus_write(ADDR_CTRL, 16'h0004);
        push_exp(K_RST, 16'd0, "R10 release reset");
        bus_write(ADDR_CTRL, 16'h1205);
        push_exp(K_RST, 16'd1, "R10 upper byte ignored");
        exp_read(ADDR_CTRL, 16'h0005, "R10 upper byte reads zero");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule